// File: doc/BRIEF.md
# Prescaled 64-bit System Timer with Compare Channels

This block is a system timer for a processor subsystem. A programmable prescaler divides the input clock into a tick. Each tick advances a free-running 64-bit count. A set of compare channels watches the low 32 bits of that count. When the count steps onto a channel's compare value, the channel raises a pending flag. Pending flags that software has enabled drive a level interrupt. The highest-numbered channel can also produce a one-cycle watchdog reset pulse.

Software reaches everything through a plain 32-bit register port with a write strobe, a byte address and a combinational read path. A consistent 64-bit value cannot be taken from two separate word reads of a moving counter. To get one, software first writes a snapshot command, which copies the whole count into a read-only register pair in a single cycle. It then reads that pair at leisure.

Software can also load either counter word at any time. A load restarts the prescaler, so a new count always lasts a full tick.

Top module: `tick_timer64`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `wdog_rst` is low.
- R2: With the divider register (offset 0x2C) holding D, the count advances by one every 2·(D+1) clock cycles.
- R3: The count is 64 bits wide. The low word reads at 0x00 and the high word at 0x04. A carry out of the low word increments the high word.
- R4: A write to 0x00 or 0x04 replaces that counter word at the next clock edge and restarts the prescaler. The next increment comes 2·(D+1) cycles after that edge, and a tick that falls in the write cycle is dropped.
- R5: Writing a value with bit 0 set to 0x30 copies the current count into the snapshot pair (low word at 0x34, high word at 0x38) at the next edge. A write with bit 0 clear changes nothing, and 0x30 reads 0.
- R6: Compare channel n (value at 0x08+4·n, n = 0..5) sets pending bit n of 0x20 at the edge where a tick moves the low word onto the compare value. Loading the counter with that value sets nothing, and neither does holding at that value between ticks.
- R7: Pending bits are cleared by writing 1 to them at 0x20, and bits written 0 keep their state. A compare hit in the same cycle as the clear wins, leaving the bit set.
- R8: `irq` is high exactly while some pending bit n is set whose enable bit n in 0x24 is set. Changing one enable bit leaves the others alone.
- R9: When bit 0 of 0x28 is set, a hit on channel 5 drives `wdog_rst` high for exactly one cycle, starting at the edge that sets pending bit 5. While bit 0 of 0x28 is clear, `wdog_rst` stays low.
- R10: Compare, enable, watchdog-enable and divider registers read back what was written (enable 6 bits, watchdog enable 1 bit). Offsets beyond 0x38 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
A 32-bit compare value is almost never reached by a free-running count, so a compare hit is the hardest event to reach from the ports. The stimulus handles this in two ways. It reads the reference count and programs compare values a few ticks ahead of it. It also loads the counter just below a compare value, which exercises the timing of the hit. Two collisions need exact cycle placement: a counter load on the cycle a tick would fire, and a pending-bit clear on the cycle a hit lands. The random phase keeps the divider small and writes often, so that both collisions happen many times.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned NUM_CH  = 6;
    localparam int unsigned ADDR_W  = 8;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int unsigned DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    localparam int unsigned PW = DIV_W + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } state_t;

    state_t s_d, s_q;
    logic [PW-1:0] limit;

    // period = 2*(div+1) clocks: terminal count is 2*div+1
    assign limit = {div, 1'b1};
    assign tick  = !restart && (s_q.cnt >= limit);

    always_comb begin
        s_d = s_q;
        if (restart || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int unsigned WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  snap,
    input  logic [WORD_W-1:0]     wdata,
    output logic [2*WORD_W-1:0]   cnt,
    output logic [2*WORD_W-1:0]   lat,
    output logic                  adv,
    output logic [WORD_W-1:0]     lo_next
);
    localparam int unsigned CW = 2 * WORD_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lat;
    } state_t;

    state_t s_d, s_q;
    logic [CW-1:0] inc;

    assign inc     = s_q.cnt + 1'b1;
    assign adv     = step && !wr_lo && !wr_hi;
    assign lo_next = inc[WORD_W-1:0];
    assign cnt     = s_q.cnt;
    assign lat     = s_q.lat;

    always_comb begin
        s_d = s_q;
        if (adv) begin
            s_d.cnt = inc;
        end
        if (wr_lo) begin
            s_d.cnt[WORD_W-1:0] = wdata;
        end
        if (wr_hi) begin
            s_d.cnt[CW-1:WORD_W] = wdata;
        end
        if (snap) begin
            s_d.lat = s_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tt_match_chan.sv
module tt_match_chan #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_val,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              en_val,
    input  logic              adv,
    input  logic [WORD_W-1:0] lo_next,
    output logic [WORD_W-1:0] match_val,
    output logic              pend,
    output logic              en,
    output logic              hit
);
    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic              pend;
        logic              en;
    } state_t;

    state_t s_d, s_q;

    // only a tick that lands on the value counts; loads and holds do not
    assign hit       = adv && (lo_next == s_q.val);
    assign match_val = s_q.val;
    assign pend      = s_q.pend;
    assign en        = s_q.en;

    always_comb begin
        s_d      = s_q;
        s_d.pend = (s_q.pend && !clr) || hit;
        if (wr_val) begin
            s_d.val = wdata;
        end
        if (wr_en) begin
            s_d.en = en_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64 #(
    parameter int unsigned WORD_W = tt_pkg::WORD_W,
    parameter int unsigned NUM_CH = tt_pkg::NUM_CH,
    parameter int unsigned ADDR_W = tt_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdog_rst
);
    localparam int unsigned CW         = 2 * WORD_W;
    localparam int unsigned WDOG_CH    = NUM_CH - 1;
    localparam int unsigned OFF_CNT_LO = 0;
    localparam int unsigned OFF_CNT_HI = 4;
    localparam int unsigned OFF_MATCH  = 8;
    localparam int unsigned OFF_STATUS = OFF_MATCH + 4 * NUM_CH;
    localparam int unsigned OFF_IEN    = OFF_STATUS + 4;
    localparam int unsigned OFF_WDEN   = OFF_STATUS + 8;
    localparam int unsigned OFF_DIV    = OFF_STATUS + 12;
    localparam int unsigned OFF_SNAP   = OFF_STATUS + 16;
    localparam int unsigned OFF_LAT_LO = OFF_STATUS + 20;
    localparam int unsigned OFF_LAT_HI = OFF_STATUS + 24;

    typedef struct packed {
        logic [WORD_W-1:0] div;
        logic              wden;
        logic              wdog;
    } state_t;

    state_t s_d, s_q;

    logic              wr_lo, wr_hi, wr_status, wr_ien, wr_wden, wr_div, wr_snap;
    logic              tick_w, adv_w;
    logic [WORD_W-1:0] lo_next_w;
    logic [CW-1:0]     cnt_w, lat_w;
    logic [NUM_CH-1:0] pend_w, en_w, hit_w;
    logic [WORD_W-1:0] match_w [NUM_CH];

    assign wr_lo     = bus_wen && (bus_addr == ADDR_W'(OFF_CNT_LO));
    assign wr_hi     = bus_wen && (bus_addr == ADDR_W'(OFF_CNT_HI));
    assign wr_status = bus_wen && (bus_addr == ADDR_W'(OFF_STATUS));
    assign wr_ien    = bus_wen && (bus_addr == ADDR_W'(OFF_IEN));
    assign wr_wden   = bus_wen && (bus_addr == ADDR_W'(OFF_WDEN));
    assign wr_div    = bus_wen && (bus_addr == ADDR_W'(OFF_DIV));
    assign wr_snap   = bus_wen && (bus_addr == ADDR_W'(OFF_SNAP)) && bus_wdata[0];

    tt_prescaler #(.DIV_W(WORD_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (s_q.div),
        .restart (wr_lo || wr_hi),
        .tick    (tick_w)
    );

    tt_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tick_w),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .snap    (wr_snap),
        .wdata   (bus_wdata),
        .cnt     (cnt_w),
        .lat     (lat_w),
        .adv     (adv_w),
        .lo_next (lo_next_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tt_match_chan #(.WORD_W(WORD_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_val    (bus_wen && (bus_addr == ADDR_W'(OFF_MATCH + 4 * i))),
            .wdata     (bus_wdata),
            .clr       (wr_status && bus_wdata[i]),
            .wr_en     (wr_ien),
            .en_val    (bus_wdata[i]),
            .adv       (adv_w),
            .lo_next   (lo_next_w),
            .match_val (match_w[i]),
            .pend      (pend_w[i]),
            .en        (en_w[i]),
            .hit       (hit_w[i])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.wdog = hit_w[WDOG_CH] && s_q.wden;
        if (wr_wden) begin
            s_d.wden = bus_wdata[0];
        end
        if (wr_div) begin
            s_d.div = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq      = |(pend_w & en_w);
    assign wdog_rst = s_q.wdog;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CNT_LO)) bus_rdata = cnt_w[WORD_W-1:0];
        if (bus_addr == ADDR_W'(OFF_CNT_HI)) bus_rdata = cnt_w[CW-1:WORD_W];
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(OFF_MATCH + 4 * i)) bus_rdata = match_w[i];
        end
        if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = WORD_W'(pend_w);
        if (bus_addr == ADDR_W'(OFF_IEN))    bus_rdata = WORD_W'(en_w);
        if (bus_addr == ADDR_W'(OFF_WDEN))   bus_rdata = WORD_W'(s_q.wden);
        if (bus_addr == ADDR_W'(OFF_DIV))    bus_rdata = s_q.div;
        if (bus_addr == ADDR_W'(OFF_LAT_LO)) bus_rdata = lat_w[WORD_W-1:0];
        if (bus_addr == ADDR_W'(OFF_LAT_HI)) bus_rdata = lat_w[CW-1:WORD_W];
    end
endmodule

// File: rtl/tt_timer_chk.sv
module tt_timer_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wen,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic                irq,
    input logic                wdog_rst,
    input logic                tick,
    input logic [2*WORD_W-1:0] cnt,
    input logic [2*WORD_W-1:0] lat,
    input logic [NUM_CH-1:0]   pend,
    input logic [NUM_CH-1:0]   hit,
    input logic                wden
);
    localparam int unsigned OFF_STATUS = 8 + 4 * NUM_CH;
    localparam int unsigned OFF_SNAP   = OFF_STATUS + 16;

    logic cnt_wr, snap_wr, clr0_wr;
    assign cnt_wr  = bus_wen && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(4));
    assign snap_wr = bus_wen && (bus_addr == ADDR_W'(OFF_SNAP)) && bus_wdata[0];
    assign clr0_wr = bus_wen && (bus_addr == ADDR_W'(OFF_STATUS)) && bus_wdata[0];

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> (cnt == $past(cnt)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

    // R5
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_wr |=> (lat == $past(cnt)));

    // R6
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> pend[0]);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0_wr && !hit[0]) |=> !pend[0]);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);

    // R9
    wdog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    // R9
    wdog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wden |=> !wdog_rst);
endmodule

bind tick_timer64 tt_timer_chk #(
    .WORD_W (WORD_W),
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .wdog_rst  (wdog_rst),
    .tick      (tick_w),
    .cnt       (cnt_w),
    .lat       (lat_w),
    .pend      (pend_w),
    .hit       (hit_w),
    .wden      (s_q.wden)
);

// File: tb/tick_timer64_test.sv
module tick_timer64_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wen = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq, wdog_rst;

    int checks = 0;
    int errors = 0;
    int wpulses = 0;
    bit mon_on = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tick_timer64 uut (
        .clk(clk), .rst_n(rst_n), .bus_wen(wen), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    // reference model, built from the requirements
    logic [63:0] m_cnt, m_lat, m_old;
    logic [32:0] m_presc;
    logic [31:0] m_div;
    logic [31:0] m_match [6];
    logic [5:0]  m_st, m_ien, m_hit, m_clr;
    logic        m_wden, m_wdog, m_restart, m_tick;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_lat = '0; m_presc = '0; m_div = '0;
            for (int n = 0; n < 6; n++) m_match[n] = '0;
            m_st = '0; m_ien = '0; m_wden = 1'b0; m_wdog = 1'b0;
        end else begin
            m_old     = m_cnt;
            m_restart = wen && (addr == 8'h00 || addr == 8'h04);
            m_tick    = !m_restart && (m_presc >= {m_div, 1'b1});
            m_presc   = (m_restart || m_tick) ? 33'd0 : m_presc + 33'd1;
            m_hit     = '0;
            for (int n = 0; n < 6; n++)
                if (m_tick && (m_old[31:0] + 32'd1) == m_match[n]) m_hit[n] = 1'b1;
            m_wdog = m_hit[5] && m_wden;
            m_clr  = (wen && addr == 8'h20) ? wdata[5:0] : 6'h0;
            m_st   = (m_st & ~m_clr) | m_hit;
            if (m_tick) m_cnt = m_old + 64'd1;
            if (wen) begin
                if (addr == 8'h00) m_cnt[31:0]  = wdata;
                if (addr == 8'h04) m_cnt[63:32] = wdata;
                for (int n = 0; n < 6; n++)
                    if (addr == 8'(8 + 4 * n)) m_match[n] = wdata;
                if (addr == 8'h24) m_ien  = wdata[5:0];
                if (addr == 8'h28) m_wden = wdata[0];
                if (addr == 8'h2C) m_div  = wdata;
                if (addr == 8'h30 && wdata[0]) m_lat = m_old;
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a == 8'h00) return m_cnt[31:0];
        if (a == 8'h04) return m_cnt[63:32];
        for (int n = 0; n < 6; n++) if (a == 8'(8 + 4 * n)) return m_match[n];
        if (a == 8'h20) return {26'h0, m_st};
        if (a == 8'h24) return {26'h0, m_ien};
        if (a == 8'h28) return {31'h0, m_wden};
        if (a == 8'h2C) return m_div;
        if (a == 8'h34) return m_lat[31:0];
        if (a == 8'h38) return m_lat[63:32];
        return 32'h0;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a <= 8'h04) return "R3";
        if (a < 8'h20)  return "R10";
        if (a == 8'h20) return "R7";
        if (a == 8'h24) return "R8";
        if (a == 8'h28) return "R9";
        if (a == 8'h2C) return "R2";
        if (a <= 8'h38) return "R5";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle output monitor (R8 irq level, R9 pulse)
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R8", {63'h0, irq}, {63'h0, |(m_st & m_ien)});
            chk("R9", {63'h0, wdog_rst}, {63'h0, m_wdog});
            if (wdog_rst) wpulses++;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wen = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic rd_model(logic [7:0] a, string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, {32'h0, v}, {32'h0, exp_read(a)});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s;
        s = $urandom(1234);
        idle(3);
        @(negedge clk);
        // R1: reset state, including an unmapped offset
        chk("R1", {63'h0, irq}, 64'h0);
        chk("R1", {63'h0, wdog_rst}, 64'h0);
        for (int a = 0; a <= 8'h38; a += 4) begin
            rd(8'(a), v);
            chk("R1", {32'h0, v}, 64'h0);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R4: load, then first increment one full period (div=1 -> 4 clocks) later
        wr(8'h2C, 32'd1);
        wr(8'h00, 32'h50);
        rd(8'h00, v); chk("R4", {32'h0, v}, 64'h50);
        idle(3);
        rd(8'h00, v); chk("R4", {32'h0, v}, 64'h50);
        idle(1);
        rd(8'h00, v); chk("R4", {32'h0, v}, 64'h51);

        // R2: divider 3 -> 8 clocks per count
        wr(8'h2C, 32'd3);
        wr(8'h00, 32'h0);
        idle(8 * 5);
        rd(8'h00, v); chk("R2", {32'h0, v}, 64'h5);
        rd_model(8'h00, "R2");

        // R3: carry into the high word
        wr(8'h2C, 32'd0);
        wr(8'h04, 32'h7);
        wr(8'h00, 32'hFFFF_FFFE);
        idle(4);
        rd(8'h00, v); chk("R3", {32'h0, v}, 64'h0);
        rd(8'h04, v); chk("R3", {32'h0, v}, 64'h8);

        // R5: snapshot, then write with bit 0 clear changes nothing
        wr(8'h30, 32'h1);
        rd_model(8'h34, "R5");
        rd_model(8'h38, "R5");
        rd(8'h38, v); chk("R5", {32'h0, v}, 64'h8);
        idle(6);
        wr(8'h30, 32'hFFFF_FFFE);
        rd(8'h34, v); chk("R5", {32'h0, v}, {32'h0, m_lat[31:0]});
        rd(8'h30, v); chk("R5", {32'h0, v}, 64'h0);

        // R6: a load onto the compare value does not set pending
        wr(8'h20, 32'h3F);
        wr(8'h08, 32'h100);
        wr(8'h00, 32'h100);
        idle(6);
        rd(8'h20, v); chk("R6", {32'h0, v}, 64'h0);
        wr(8'h00, 32'hFF);
        idle(3);
        rd(8'h20, v); chk("R6", {32'h0, v}, 64'h1);

        // R7: write-one-to-clear, zero bits keep state
        wr(8'h20, 32'h0);
        rd(8'h20, v); chk("R7", {32'h0, v}, 64'h1);
        wr(8'h20, 32'h1);
        rd(8'h20, v); chk("R7", {32'h0, v}, 64'h0);

        // R8: irq follows enable
        wr(8'h0C, 32'h200);
        wr(8'h00, 32'h1FD);
        idle(6);
        chk("R8", {63'h0, irq}, 64'h0);
        wr(8'h24, 32'h2);
        chk("R8", {63'h0, irq}, 64'h1);
        wr(8'h24, 32'h1);
        chk("R8", {63'h0, irq}, 64'h0);
        wr(8'h20, 32'h3F);

        // R9: watchdog pulse enabled, then gated off
        wpulses = 0;
        wr(8'h28, 32'h1);
        wr(8'h1C, 32'h300);
        wr(8'h00, 32'h2FE);
        idle(8);
        chk("R9", 64'(wpulses), 64'd1);
        wr(8'h28, 32'h0);
        wr(8'h00, 32'h2FE);
        idle(8);
        chk("R9", 64'(wpulses), 64'd1);
        rd(8'h20, v); chk("R9", {32'h0, v}, 64'h20);

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom_range(0, 9));
            if (op <= 2) begin
                a = 8'(8 + 4 * $urandom_range(0, 5));
                wr(a, m_cnt[31:0] + $urandom_range(1, 30));
            end else if (op == 3) begin
                wr(8'h20, $urandom);
            end else if (op == 4) begin
                a = ($urandom_range(0, 3) == 0) ? 8'h2C : 8'(4 * $urandom_range(9, 12));
                wr(a, (a == 8'h2C) ? 32'($urandom_range(0, 2)) : $urandom);
            end else if (op == 5) begin
                wr(8'(4 * $urandom_range(0, 1)), $urandom);
            end else if (op == 6) begin
                wr(8'h30, $urandom);
            end else begin
                a = 8'(4 * $urandom_range(0, 20));
                rd_model(a, tag_of(a));
                idle(1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule